// File: doc/BRIEF.md
# Configuration Port Buffer Transfer Controller

This block moves a run of bytes between a shared dual-port buffer RAM and a byte-wide internal configuration port. A host processor owns one port of the RAM. The controller owns the other port. The host prepares a transfer through three small registers: a byte count, the buffer address of the first byte, and a direction bit. It then writes a start bit.

In a configuration transfer, bytes are fetched from the buffer and presented to the port. In a readback transfer, bytes produced by the port are stored into the buffer. The port may hold off any byte with its busy line. The controller stalls on that byte without losing or repeating it. When the count runs out, the controller releases chip-enable and sets a done flag that the host can poll.

The controller's buffer port is assumed to read synchronously with one cycle of latency. It is also assumed to keep its output while it is not enabled. Buffer addresses wrap at the buffer depth.

Top module: `cfgport_xfer_ctrl`

## Requirements
- R1: Reset behaviour:
  - During reset (synchronous, active-low `rst_n`), `cp_ce_n` and `cp_write_n` are 1 and `buf_we` is 0.
  - After reset, the control, count and base registers all read 0.
- R2: Register map:
  - Register 0 is control. Bit 0 is the start bit; it is written only and reads 0. Bit 1 is the direction: 1 = readback, 0 = configure. Bit 2 is the done flag and is read only.
  - Register 1 is the byte count, in bits [15:0].
  - Register 2 is the buffer base address, in bits [9:0].
  - The count, base and direction bit read back as last written.
- R3: Configuration transfer (direction 0):
  - Buffer bytes base, base+1, … are presented on `cp_din` in that order, with `cp_write_n` = 0.
  - The port takes exactly one byte at each rising edge where `cp_ce_n` = 0 and `cp_busy` = 0.
  - `buf_we` stays 0.
- R4: Readback transfer (direction 1):
  - At each rising edge with `cp_ce_n` = 0 and `cp_busy` = 0, the byte on `cp_dout` is written to the next buffer address, starting at base. `cp_write_n` is 1.
  - The buffer byte just past the last written address is not changed.
- R5: Busy stall: at an edge where `cp_busy` = 1, no byte is taken and no buffer write happens. `cp_ce_n`, `cp_din` and `buf_addr` hold their values into the next cycle.
- R6: Chip-enable timing:
  - In a configuration transfer, `cp_ce_n` falls in the second cycle after the edge that accepts start. The cycle in between fetches the first byte.
  - In a readback transfer, `cp_ce_n` falls in the first cycle after that edge.
- R7: Done flag:
  - Accepting a start with a nonzero count clears done.
  - Done is set at the same edge where the last byte is taken. `cp_ce_n` returns to 1 at that edge.
  - Done is never 1 while `cp_ce_n` = 0.
- R8: Start written while a transfer runs is ignored. A count change or direction change written during the run does not alter that transfer.
- R9: Start with a count of 0 sets done at the accepting edge and never asserts `cp_ce_n`.
- R10: Buffer addresses wrap modulo 1024. A transfer as long as a header, a data frame and a pad frame (300 bytes here), which crosses the wrap point, completes with every byte in order.
- R11: `cp_write_n` keeps one level for the whole time `cp_ce_n` is low in a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 32 | Host register write data |
| reg_rdata | output | 32 | Host register read data (combinational on reg_addr) |
| buf_en | output | 1 | Buffer port enable |
| buf_we | output | 1 | Buffer port write enable |
| buf_addr | output | 10 | Buffer port address |
| buf_wdata | output | 8 | Buffer port write data |
| buf_rdata | input | 8 | Buffer port read data, one cycle after enable |
| cp_ce_n | output | 1 | Configuration port chip-enable, active low |
| cp_write_n | output | 1 | Configuration port direction, 0 = configure, 1 = readback |
| cp_din | output | 8 | Byte to the configuration port |
| cp_dout | input | 8 | Byte from the configuration port |
| cp_busy | input | 1 | Configuration port busy, stalls the current byte |

## Verification
The busy stall and the end of a transfer can land in the same cycle. When busy is high while the final byte is on the port, done must wait and chip-enable must stay low until the first busy-free edge. The bench drives a repeating busy pattern whose phase falls differently against the last byte in each transfer. A per-cycle model predicts chip-enable, the write level and done, and judges both the stalled and the unstalled ending. A start written in the middle of a running transfer is another such overlap. It is judged by the byte count, the byte order and the write level that reach the port.

// File: rtl/cpx_pkg.sv
// Shared definitions for the configuration-port transfer controller.
// Assumes a 32-bit host register bus with word-select addresses.
package cpx_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREF = 2'd1,
        PH_MOVE = 2'd2
    } phase_t;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_SIZE = 2'd1;
    localparam logic [1:0] RA_BASE = 2'd2;

    localparam int CTL_GO   = 0;
    localparam int CTL_RDBK = 1;
    localparam int CTL_DONE = 2;

    localparam int HOST_W = 32;
endpackage

// File: rtl/cpx_regs.sv
// Host register file: control (start, direction, done), byte count, base address.
// Assumes CNT_W and ADDR_W are not wider than the host bus.
module cpx_regs
    import cpx_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [HOST_W-1:0] reg_wdata,
    output logic [HOST_W-1:0] reg_rdata,
    input  logic              eng_begin,
    input  logic              eng_end,
    output logic              go_req,
    output logic              rdbk_eff,
    output logic [CNT_W-1:0]  size_q,
    output logic [ADDR_W-1:0] base_q
);
    logic rdbk_q;
    logic done_q;
    logic ctrl_wr;

    assign ctrl_wr  = reg_we && (reg_addr == RA_CTRL);
    assign go_req   = ctrl_wr && reg_wdata[CTL_GO];
    // A start written together with a direction uses the new direction.
    assign rdbk_eff = ctrl_wr ? reg_wdata[CTL_RDBK] : rdbk_q;

    // Register writes from the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdbk_q <= 1'b0;
            size_q <= '0;
            base_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL: rdbk_q <= reg_wdata[CTL_RDBK];
                RA_SIZE: size_q <= reg_wdata[CNT_W-1:0];
                RA_BASE: base_q <= reg_wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    // Done flag: set on finish, cleared when a real transfer begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (eng_end) begin
            done_q <= 1'b1;
        end else if (eng_begin) begin
            done_q <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTL_RDBK] = rdbk_q;
                reg_rdata[CTL_DONE] = done_q;
            end
            RA_SIZE: reg_rdata[CNT_W-1:0]  = size_q;
            RA_BASE: reg_rdata[ADDR_W-1:0] = base_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cpx_engine.sv
// Transfer sequencer: walks the buffer, drives the port strobes, stalls on busy.
// Assumes the buffer port reads with one cycle latency and holds its output while disabled.
module cpx_engine
    import cpx_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_req,
    input  logic              rdbk_in,
    input  logic [CNT_W-1:0]  size_in,
    input  logic [ADDR_W-1:0] base_in,
    output logic              eng_begin,
    output logic              eng_end,
    output logic              buf_en,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [BYTE_W-1:0] buf_wdata,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              cp_ce_n,
    output logic              cp_write_n,
    output logic [BYTE_W-1:0] cp_din,
    input  logic [BYTE_W-1:0] cp_dout,
    input  logic              cp_busy
);
    phase_t            phase;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  remain;
    logic              rdbk_q;
    logic              idle;
    logic              moving;
    logic              take;
    logic              last;
    logic              size_zero;

    assign idle      = (phase == PH_IDLE);
    assign moving    = (phase == PH_MOVE);
    assign take      = moving && !cp_busy;
    assign last      = (remain == CNT_W'(1));
    assign size_zero = (size_in == '0);

    assign eng_begin = idle && go_req && !size_zero;
    assign eng_end   = (idle && go_req && size_zero) || (take && last);

    // Phase, pointer, remaining count and latched direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            ptr    <= '0;
            remain <= '0;
            rdbk_q <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (eng_begin) begin
                        rdbk_q <= rdbk_in;
                        ptr    <= base_in;
                        remain <= size_in;
                        phase  <= rdbk_in ? PH_MOVE : PH_PREF;
                    end
                end
                PH_PREF: phase <= PH_MOVE;
                PH_MOVE: begin
                    if (take) begin
                        ptr    <= ptr + ADDR_W'(1);
                        remain <= remain - CNT_W'(1);
                        if (last) begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Port strobes follow the registered phase and direction.
    always_comb begin
        cp_ce_n    = !moving;
        cp_write_n = rdbk_q;
        cp_din     = rdbk_q ? '0 : buf_rdata;
    end

    // Buffer port: prefetch ahead on configure, write behind on readback.
    always_comb begin
        buf_addr  = (moving && !rdbk_q) ? ptr + ADDR_W'(1) : ptr;
        buf_en    = (phase == PH_PREF) || (take && (rdbk_q || !last));
        buf_we    = take && rdbk_q;
        buf_wdata = cp_dout;
    end
endmodule

// File: rtl/cfgport_xfer_ctrl.sv
// Top: host registers plus a transfer sequencer between a buffer RAM port and
// a byte-serial configuration port with a busy-stall handshake.
// Assumes the host reaches the buffer through the RAM's other port.
module cfgport_xfer_ctrl
    import cpx_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              buf_en,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [BYTE_W-1:0] buf_wdata,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              cp_ce_n,
    output logic              cp_write_n,
    output logic [BYTE_W-1:0] cp_din,
    input  logic [BYTE_W-1:0] cp_dout,
    input  logic              cp_busy
);
    logic              go_req;
    logic              rdbk_eff;
    logic [CNT_W-1:0]  size_q;
    logic [ADDR_W-1:0] base_q;
    logic              eng_begin;
    logic              eng_end;

    cpx_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .eng_begin (eng_begin),
        .eng_end   (eng_end),
        .go_req    (go_req),
        .rdbk_eff  (rdbk_eff),
        .size_q    (size_q),
        .base_q    (base_q)
    );

    cpx_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_req     (go_req),
        .rdbk_in    (rdbk_eff),
        .size_in    (size_q),
        .base_in    (base_q),
        .eng_begin  (eng_begin),
        .eng_end    (eng_end),
        .buf_en     (buf_en),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .buf_wdata  (buf_wdata),
        .buf_rdata  (buf_rdata),
        .cp_ce_n    (cp_ce_n),
        .cp_write_n (cp_write_n),
        .cp_din     (cp_din),
        .cp_dout    (cp_dout),
        .cp_busy    (cp_busy)
    );
endmodule

// File: rtl/cpx_checker.sv
// Protocol checker for the transfer controller, bound to its top module.
// Assumes the buffer RAM holds its read output while its enable is low.
module cpx_checker
    import cpx_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              cp_ce_n,
    input logic              cp_write_n,
    input logic [BYTE_W-1:0] cp_din,
    input logic              cp_busy
);
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_ce_n && cp_busy) |=> (!cp_ce_n && $stable(cp_din) && $stable(buf_addr))); // R5
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cp_busy |-> !buf_we); // R5
    AST_WRITE_LEVEL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_ce_n && $past(!cp_ce_n)) |-> $stable(cp_write_n)); // R11
    AST_CFG_NO_BUF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_write_n |-> !buf_we); // R3
    AST_DONE_OFF_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_ce_n && reg_addr == RA_CTRL) |-> !reg_rdata[CTL_DONE]); // R7
endmodule

bind cfgport_xfer_ctrl cpx_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .cp_ce_n    (cp_ce_n),
    .cp_write_n (cp_write_n),
    .cp_din     (cp_din),
    .cp_busy    (cp_busy)
);

// File: tb/test_cfgport_xfer_ctrl.sv
// Bench: buffer RAM and port models, a behavioural per-cycle model, directed transfers.
module test_cfgport_xfer_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        buf_en, buf_we;
    logic [9:0]  buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = 8'd0;
    logic        cp_ce_n, cp_write_n;
    logic [7:0]  cp_din;
    logic [7:0]  cp_dout;
    logic        cp_busy = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cfgport_xfer_ctrl i_cfgport_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_en(buf_en),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .cp_ce_n(cp_ce_n), .cp_write_n(cp_write_n),
        .cp_din(cp_din), .cp_dout(cp_dout), .cp_busy(cp_busy)
    );

    // Buffer RAM, controller side; the host side is direct array access.
    logic [7:0] mem [0:1023];
    always @(posedge clk) begin
        if (buf_en) begin
            if (buf_we) mem[buf_addr] <= buf_wdata;
            else        buf_rdata <= mem[buf_addr];
        end
    end

    function automatic logic [7:0] rb_pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // Port model: records configured bytes, supplies readback bytes.
    logic [7:0] got_mem [0:4095];
    int got_cnt = 0;
    int rb_idx = 0;
    int ce_low_cnt = 0;
    assign cp_dout = rb_pat(rb_idx);
    always @(posedge clk) begin
        if (!cp_ce_n && !cp_busy) begin
            if (!cp_write_n) begin
                got_mem[got_cnt % 4096] <= cp_din;
                got_cnt <= got_cnt + 1;
            end else begin
                rb_idx <= rb_idx + 1;
            end
        end
        if (!cp_ce_n) ce_low_cnt <= ce_low_cnt + 1;
    end

    // Busy pattern: two stalled cycles out of every five when enabled.
    bit busy_on = 1'b0;
    int cyc = 0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        cp_busy = busy_on && ((cyc % 5 == 1) || (cyc % 5 == 2));
    end

    // Reference model: phase 0 idle, 1 fetch, 2 moving.
    int m_phase = 0;
    int m_rem = 0;
    bit m_dir = 1'b1;
    bit m_done = 1'b0;
    bit s_dir = 1'b0;
    int s_size = 0;
    int s_base = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_rem = 0; m_dir = 1'b1; m_done = 1'b0;
            s_dir = 1'b0; s_size = 0; s_base = 0;
        end else begin
            case (m_phase)
                0: if (reg_we && reg_addr == 2'd0 && reg_wdata[0]) begin
                    if (s_size == 0) m_done = 1'b1;
                    else begin
                        m_done = 1'b0; m_dir = reg_wdata[1]; m_rem = s_size;
                        m_phase = m_dir ? 2 : 1;
                    end
                end
                1: m_phase = 2;
                default: if (!cp_busy) begin
                    m_rem = m_rem - 1;
                    if (m_rem == 0) begin m_phase = 0; m_done = 1'b1; end
                end
            endcase
            if (reg_we) begin
                case (reg_addr)
                    2'd0: s_dir = reg_wdata[1];
                    2'd1: s_size = int'(reg_wdata[15:0]);
                    2'd2: s_base = int'(reg_wdata[9:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, mid low phase.
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            chk(cp_ce_n == (m_phase != 2), "R6 ce_n vs model", cp_ce_n, m_phase != 2);
            chk(cp_write_n == m_dir, "R11 write_n vs model", cp_write_n, m_dir);
            if (reg_addr == 2'd0) begin
                chk(reg_rdata[2] == m_done, "R7 done vs model", reg_rdata[2], m_done);
                chk(reg_rdata[1] == s_dir, "R2 dir readback", reg_rdata[1], s_dir);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #5 v = reg_rdata;
        @(negedge clk);
        reg_addr = 2'd0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_phase != 0);
        @(negedge clk);
    endtask

    task automatic run_cfg(input int base, input int size, input string tag);
        int g0;
        int bad;
        logic [31:0] v;
        wr(2'd2, 32'(base));
        wr(2'd1, 32'(size));
        g0 = got_cnt;
        wr(2'd0, 32'h1);
        #5 chk(cp_ce_n == 1'b1, "R6 cfg fetch cycle ce_n", cp_ce_n, 1);
        @(negedge clk);
        #5 chk(cp_ce_n == 1'b0, "R6 cfg ce_n low", cp_ce_n, 0);
        rd(2'd0, v);
        chk(v[2] == 1'b0 || size <= 2, "R7 done cleared by start", v[2], 0);
        wait_idle();
        chk(got_cnt - g0 == size, {tag, " byte count"}, got_cnt - g0, size);
        bad = 0;
        for (int i = 0; i < size; i++)
            if (got_mem[(g0 + i) % 4096] != mem[(base + i) % 1024]) bad++;
        chk(bad == 0, {tag, " byte order"}, bad, 0);
        rd(2'd0, v);
        chk(v[2] == 1'b1, "R7 done after config", v[2], 1);
    endtask

    task automatic run_rb(input int base, input int size);
        int r0;
        int bad;
        logic [7:0] guard;
        guard = mem[(base + size) % 1024];
        wr(2'd2, 32'(base));
        wr(2'd1, 32'(size));
        r0 = rb_idx;
        wr(2'd0, 32'h3);
        #5 chk(cp_ce_n == 1'b0, "R6 readback ce_n low", cp_ce_n, 0);
        wait_idle();
        chk(rb_idx - r0 == size, "R4 bytes read", rb_idx - r0, size);
        bad = 0;
        for (int i = 0; i < size; i++)
            if (mem[(base + i) % 1024] != rb_pat(r0 + i)) bad++;
        chk(bad == 0, "R4 buffer contents", bad, 0);
        chk(mem[(base + size) % 1024] == guard, "R4 byte past end untouched",
            mem[(base + size) % 1024], guard);
    endtask

    initial begin
        #(20 * 100000);
        chk(1'b0, "R3 watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int c0;
        int g0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 13 + 5) ^ (i >> 3));
        repeat (3) @(negedge clk);
        #5;
        chk(cp_ce_n == 1'b1, "R1 ce_n in reset", cp_ce_n, 1);
        chk(cp_write_n == 1'b1, "R1 write_n in reset", cp_write_n, 1);
        chk(buf_we == 1'b0, "R1 buf_we in reset", buf_we, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, v); chk(v == 0, "R1 control after reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 count after reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 base after reset", v, 0);

        // R9: zero count from a cleared done flag.
        c0 = ce_low_cnt;
        wr(2'd0, 32'h1);
        #5 chk(reg_rdata[2] == 1'b1, "R9 done at once", reg_rdata[2], 1);
        repeat (4) @(negedge clk);
        chk(ce_low_cnt == c0, "R9 no chip-enable", ce_low_cnt - c0, 0);

        // R2: register readback.
        wr(2'd1, 32'h0000_1234);
        wr(2'd2, 32'h0000_0155);
        rd(2'd1, v); chk(v == 32'h1234, "R2 count readback", v, 32'h1234);
        rd(2'd2, v); chk(v == 32'h155, "R2 base readback", v, 32'h155);

        run_cfg(16, 8, "R3 cfg no stall");
        busy_on = 1'b1;
        run_cfg(40, 12, "R5 cfg with stalls");
        run_rb(200, 10);
        busy_on = 1'b0;
        run_rb(500, 7);

        // R8: start and count written mid-run are ignored.
        busy_on = 1'b1;
        wr(2'd2, 32'd100);
        wr(2'd1, 32'd20);
        g0 = got_cnt;
        wr(2'd0, 32'h1);
        repeat (3) @(negedge clk);
        wr(2'd0, 32'h3);
        wr(2'd1, 32'd3);
        wait_idle();
        chk(got_cnt - g0 == 20, "R8 count unchanged by mid-run start", got_cnt - g0, 20);
        c0 = 0;
        for (int i = 0; i < 20; i++) if (got_mem[(g0 + i) % 4096] != mem[100 + i]) c0++;
        chk(c0 == 0, "R8 bytes unchanged by mid-run start", c0, 0);
        rd(2'd1, v); chk(v == 3, "R2 count written mid-run", v, 3);

        // R10: long transfer across the wrap point.
        run_cfg(900, 300, "R10 long wrapped cfg");
        busy_on = 1'b0;
        run_rb(1020, 9);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule